// File: doc/BRIEF.md
# Banked Edge/Level Interrupt Controller

This block gathers up to 64 interrupt sources, split into two banks of 32, and presents a single interrupt request to a host processor together with the number of the source that should be served first. Each source line passes through a synchroniser. Sources marked as edge sensitive latch a rising edge into a per-bank event register, and the bit stays set until software clears it through the acknowledge register. Sources marked as level sensitive by a fixed per-bank mask are not latched. They are taken directly from the synchronised line for as long as it is high.

Software reaches each bank through a simple synchronous register port with four word registers: event, enable, acknowledge and level. A source is pending when its event bit is set, or when it is a level source with an active line, and it is also enabled. The request output is high while any source is pending. The number output names the highest-numbered pending source, so any source of the upper bank beats every source of the lower bank. A latched edge that was already acknowledged is not brought back by a later enable. This means that enabling a line that is already high creates no new request.

The design has no state machine. Its state is made up of the synchroniser stages, the previous-line register used for edge detection, and the event, enable and read-data registers.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset, all enable and event bits read 0 and `irq_req` is 0.
- R2: The register map uses byte addresses. Sources 0–31 sit at 0x20 (event 0x20, enable 0x24, acknowledge 0x28, level 0x2C). Sources 32–63 sit at 0x10 (event 0x10, enable 0x14, acknowledge 0x18, level 0x1C). Source n of a bank is bit n mod 32. Any other address, including one that is not word aligned, reads 0 and has no effect when written. Read data appears on `reg_rdata` one clock after the read strobe and holds until the next read.
- R3: The enable register reads back the value last written to it, and each bank's enable is independent of the other's.
- R4: A rising edge on a synchronised edge-source line (level-mask bit 0) sets that source's event bit whatever its enable state. The bit stays set after the line falls, until it is acknowledged. Event bits of level sources always read 0.
- R5: Writing the acknowledge register clears each event bit written as 1 and leaves the bits written as 0 unchanged. A rising edge in the same cycle as its acknowledge wins, so the bit stays set. The acknowledge register reads 0.
- R6: The level register shows the synchronised input lines of its bank and ignores writes. Level sources use mask 0x1FF00000 for the lower bank (sources 20–28) and 0x3FF00000 for the upper bank (sources 52–61). Such a source is pending while its line is high and enabled, and stops being pending when the line falls.
- R7: A source is pending when (event OR (line AND level mask)) AND enable. `irq_req` is the OR of every pending bit.
- R8: While `irq_req` is 1, `irq_num` is the highest-numbered pending source. This means any upper-bank source takes priority over every lower-bank source.
- R9: Setting the enable bit of an edge source whose line is already high, and whose event has been acknowledged, raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 64 | Interrupt source lines, asynchronous |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 6 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq_req | output | 1 | Interrupt request |
| irq_num | output | 6 | Number of the winning source |

## Verification
The assertions assume that a register access lasts one cycle per strobe, and that the winning-source and readback relations are checked only after reset has been released. They make no assumption about when `src_in` changes, because the synchroniser absorbs that. The stimulus drives every input on the falling clock edge. After any change of the source lines it waits four cycles, which covers the two synchroniser stages and the edge register. The expected state therefore depends only on the order of operations. The exception is the directed collision case, which places an acknowledge exactly on the cycle where the edge is detected.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
    localparam int BANK_W  = 32;
    localparam int N_BANKS = 2;
    localparam int SRC_W   = BANK_W * N_BANKS;
    localparam int NUM_W   = $clog2(SRC_W);
    localparam int ADDR_W  = 6;
    localparam int DATA_W  = BANK_W;

    typedef enum logic [1:0] {
        SLOT_EVENT  = 2'd0,
        SLOT_ENABLE = 2'd1,
        SLOT_ACK    = 2'd2,
        SLOT_LEVEL  = 2'd3
    } slot_e;
endpackage

// File: rtl/irq_bank_sync.sv
module irq_bank_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/irq_bank_slice.sv
module irq_bank_slice #(
    parameter int           W        = 32,
    parameter logic [W-1:0] LVL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] line,
    input  logic         en_wr,
    input  logic         ack_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] ev_q,
    output logic [W-1:0] en_q,
    output logic [W-1:0] pend
);
    logic [W-1:0] prev_q;
    logic [W-1:0] rise;
    logic [W-1:0] clr;

    // edge sources only; level sources never latch
    assign rise = line & ~prev_q & ~LVL_MASK;
    assign clr  = ack_wr ? wdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            ev_q   <= '0;
            en_q   <= '0;
        end else begin
            prev_q <= line;
            ev_q   <= (ev_q & ~clr) | rise;   // new edge wins over ack
            if (en_wr) en_q <= wdata;
        end
    end

    assign pend = (ev_q | (line & LVL_MASK)) & en_q;
endmodule

// File: rtl/irq_bank_prio.sv
module irq_bank_prio #(
    parameter int W  = 64,
    parameter int NW = 6
) (
    input  logic [W-1:0]  pend,
    output logic          req,
    output logic [NW-1:0] num
);
    always_comb begin
        num = '0;
        for (int i = 0; i < W; i++) begin
            if (pend[i]) num = NW'(i);
        end
        req = |pend;
    end
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
    import irq_bank_pkg::*;
#(
    parameter logic [BANK_W-1:0] LVL_MASK_LO = 32'h1ff0_0000,
    parameter logic [BANK_W-1:0] LVL_MASK_HI = 32'h3ff0_0000,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  src_in,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_req,
    output logic [NUM_W-1:0]  irq_num
);
    logic [SRC_W-1:0]   line_all;
    logic [SRC_W-1:0]   ev_all;
    logic [SRC_W-1:0]   en_all;
    logic [SRC_W-1:0]   pend_all;
    logic [N_BANKS-1:0] hit;
    logic               aligned;
    slot_e              slot;
    logic [DATA_W-1:0]  rd_mux;

    assign aligned = (reg_addr[1:0] == 2'b00);
    assign slot    = slot_e'(reg_addr[3:2]);

    irq_bank_sync #(.W(SRC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (src_in),
        .q     (line_all)
    );

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        localparam logic [BANK_W-1:0] MASK = (b == 0) ? LVL_MASK_LO : LVL_MASK_HI;
        // bank b answers at block (N_BANKS - b) * 0x10
        assign hit[b] = aligned && (reg_addr[5:4] == 2'(N_BANKS - b));

        irq_bank_slice #(.W(BANK_W), .LVL_MASK(MASK)) u_slice (
            .clk    (clk),
            .rst_n  (rst_n),
            .line   (line_all[b*BANK_W +: BANK_W]),
            .en_wr  (reg_sel && reg_wr && hit[b] && slot == SLOT_ENABLE),
            .ack_wr (reg_sel && reg_wr && hit[b] && slot == SLOT_ACK),
            .wdata  (reg_wdata),
            .ev_q   (ev_all[b*BANK_W +: BANK_W]),
            .en_q   (en_all[b*BANK_W +: BANK_W]),
            .pend   (pend_all[b*BANK_W +: BANK_W])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < N_BANKS; b++) begin
            if (hit[b]) begin
                unique case (slot)
                    SLOT_EVENT:  rd_mux = ev_all[b*BANK_W +: BANK_W];
                    SLOT_ENABLE: rd_mux = en_all[b*BANK_W +: BANK_W];
                    SLOT_ACK:    rd_mux = '0;
                    SLOT_LEVEL:  rd_mux = line_all[b*BANK_W +: BANK_W];
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                reg_rdata <= '0;
        else if (reg_sel && !reg_wr) reg_rdata <= rd_mux;
    end

    irq_bank_prio #(.W(SRC_W), .NW(NUM_W)) u_prio (
        .pend (pend_all),
        .req  (irq_req),
        .num  (irq_num)
    );
endmodule

// File: rtl/irq_bank_ctrl_chk.sv
module irq_bank_ctrl_chk
    import irq_bank_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_sel,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq_req,
    input logic [NUM_W-1:0]  irq_num,
    input logic [SRC_W-1:0]  pend_all,
    input logic [SRC_W-1:0]  en_all
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> !irq_req); // R1
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && !reg_wr && (reg_addr[5:4] == 2'b00 || reg_addr[5:4] == 2'b11 || reg_addr[1:0] != 2'b00))
        |=> reg_rdata == '0); // R2
    AST_EN_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && reg_addr == 6'h24) |=> en_all[BANK_W-1:0] == $past(reg_wdata)); // R3
    AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n) irq_req |-> pend_all[irq_num]); // R7
    AST_WINNER_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (pend_all >> irq_num) == SRC_W'(1)); // R8
endmodule

bind irq_bank_ctrl irq_bank_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_req   (irq_req),
    .irq_num   (irq_num),
    .pend_all  (pend_all),
    .en_all    (en_all)
);

// File: tb/irq_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_bank_ctrl_tb_top;
    localparam logic [31:0] MASK_LO = 32'h1ff0_0000;
    localparam logic [31:0] MASK_HI = 32'h3ff0_0000;
    localparam logic [63:0] MASK64  = {MASK_HI, MASK_LO};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_in = '0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_req;
    logic [5:0]  irq_num;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] ev_m = '0;
    logic [63:0] en_m = '0;
    logic [63:0] src_m = '0;

    always #4 clk = ~clk;

    irq_bank_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .irq_num(irq_num)
    );

    function automatic logic [63:0] exp_pend();
        return (ev_m | (src_m & MASK64)) & en_m;
    endfunction

    function automatic logic [5:0] exp_num(logic [63:0] p);
        logic [5:0] n = '0;
        for (int i = 0; i < 64; i++) if (p[i]) n = 6'(i);
        return n;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_src(logic [63:0] v);
        @(negedge clk);
        ev_m  = ev_m | (v & ~src_m & ~MASK64);
        src_m = v;
        src_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
        case (a)
            6'h24: en_m[31:0]  = d;
            6'h14: en_m[63:32] = d;
            6'h28: ev_m[31:0]  = ev_m[31:0] & ~d;
            6'h18: ev_m[63:32] = ev_m[63:32] & ~d;
            default: ;
        endcase
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_sel = 1'b0;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] exp_reg(logic [5:0] a);
        case (a)
            6'h20: return ev_m[31:0];
            6'h24: return en_m[31:0];
            6'h2C: return src_m[31:0];
            6'h10: return ev_m[63:32];
            6'h14: return en_m[63:32];
            6'h1C: return src_m[63:32];
            default: return '0;
        endcase
    endfunction

    task automatic check_irq(string tag);
        logic [63:0] p = exp_pend();
        check({tag, " irq_req"}, 64'(irq_req), 64'(|p));
        if (|p) check({tag, " irq_num"}, 64'(irq_num), 64'(exp_num(p)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq_req", 64'(irq_req), 64'd0);
        rd(6'h24, d); check("R1 enable lo", 64'(d), 64'd0);
        rd(6'h14, d); check("R1 enable hi", 64'(d), 64'd0);
        rd(6'h20, d); check("R1 event lo", 64'(d), 64'd0);

        // R2 / R3 map and readback
        wr(6'h14, 32'hA5A5_0000);
        rd(6'h14, d); check("R3 enable hi readback", 64'(d), 64'hA5A5_0000);
        rd(6'h24, d); check("R3 enable lo untouched", 64'(d), 64'd0);
        wr(6'h00, 32'hFFFF_FFFF);
        wr(6'h26, 32'hFFFF_FFFF);
        rd(6'h24, d); check("R2 unmapped write ignored", 64'(d), 64'd0);
        rd(6'h00, d); check("R2 read 0x00", 64'(d), 64'd0);
        rd(6'h30, d); check("R2 read 0x30", 64'(d), 64'd0);
        rd(6'h15, d); check("R2 read unaligned", 64'(d), 64'd0);
        wr(6'h14, 32'h0);

        // R4 edge latch regardless of enable
        set_src(64'h8);
        rd(6'h20, d); check("R4 event set while disabled", 64'(d), 64'h8);
        check("R4 no request while disabled", 64'(irq_req), 64'd0);
        set_src(64'h0);
        rd(6'h20, d); check("R4 event held after fall", 64'(d), 64'h8);
        wr(6'h24, 32'h8);
        check("R7 request on enable", 64'(irq_req), 64'd1);
        check("R7 num 3", 64'(irq_num), 64'd3);

        // R5 acknowledge
        wr(6'h28, 32'h0);
        rd(6'h20, d); check("R5 zero ack no effect", 64'(d), 64'h8);
        rd(6'h28, d); check("R5 ack reads zero", 64'(d), 64'd0);
        wr(6'h28, 32'h8);
        rd(6'h20, d); check("R5 ack clears", 64'(d), 64'd0);
        check("R5 request gone", 64'(irq_req), 64'd0);

        // R5 edge and ack in same cycle: edge wins
        @(negedge clk);
        src_in = 64'h8;
        @(negedge clk);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 6'h28; reg_wdata = 32'h8;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
        src_m = 64'h8; ev_m = 64'h8;
        rd(6'h20, d); check("R5 edge wins over ack", 64'(d), 64'h8);
        wr(6'h28, 32'h8);
        set_src(64'h0);
        wr(6'h24, 32'h0);

        // R6 level source bit 20
        wr(6'h24, 32'h0010_0000);
        set_src(64'h0010_0000);
        check("R6 level pending", 64'(irq_req), 64'd1);
        check("R6 level num", 64'(irq_num), 64'd20);
        rd(6'h20, d); check("R6 level no event", 64'(d), 64'd0);
        wr(6'h2C, 32'h0);
        rd(6'h2C, d); check("R6 level read-only", 64'(d), 64'h0010_0000);
        set_src(64'h0);
        check("R6 level drops", 64'(irq_req), 64'd0);

        // R8 upper bank beats lower
        wr(6'h24, 32'h8000_0000);
        wr(6'h14, 32'h2);
        set_src(64'h2_8000_0000);
        check("R8 upper wins num", 64'(irq_num), 64'd33);
        wr(6'h18, 32'h2);
        check("R8 lower after ack", 64'(irq_num), 64'd31);
        wr(6'h28, 32'h8000_0000);
        set_src(64'h0);
        wr(6'h24, 32'h0); wr(6'h14, 32'h0);

        // R9 enable on already-high, acknowledged edge line
        set_src(64'h20);
        wr(6'h28, 32'h20);
        wr(6'h24, 32'h20);
        check("R9 no request on late enable", 64'(irq_req), 64'd0);
        rd(6'h20, d); check("R9 event stays clear", 64'(d), 64'd0);
        set_src(64'h0);

        // random mix, R7 / R8 against model
        for (int it = 0; it < 400; it++) begin
            int op = int'($urandom % 4);
            logic [5:0] base = ($urandom % 2) ? 6'h10 : 6'h20;
            case (op)
                0: set_src({$urandom, $urandom} & {$urandom, $urandom});
                1: wr(base + 6'h4, $urandom);
                2: wr(base + 6'h8, $urandom);
                default: begin
                    logic [5:0] a = base + 6'(($urandom % 4) * 4);
                    rd(a, d);
                    check("R2 random read", 64'(d), 64'(exp_reg(a)));
                end
            endcase
            check_irq("R7 R8 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule